// File: doc/BRIEF.md
# Power-Up Recall Sequencer with Write Lockout

This controller sits between the supply monitor of a nonvolatile-backed static RAM and its array access logic. A digital flag reports when the supply is below the safe threshold. While that flag is high, including the interval right after reset, the controller holds a pending restore request and keeps the array closed to writes and to save requests. When the supply comes back, it restores the array from the nonvolatile copy in two timed phases: a clear phase and then a transfer phase. Each phase asserts its own handshake output for a parameterised number of cycles. Only after both phases complete does it raise `ready`.

The controller also owns the write gate. A write strobe pair (`ce_n`, `we_n`, both active low) that is already held active when access reopens has no effect. This applies after a restore and after a save, and it remains true until a fresh high-to-low transition appears on either strobe. The controller keeps a modified-data flag, which a passed write sets and which a completed restore or a running save clears.

Top module: `nv_recall_guard`

## Requirements
- R1: After reset, and whenever `supply_low` is high for one or more cycles, a restore request is latched. While the request waits, `ready`, `clear_phase` and `xfer_phase` stay low.
- R2: On the first clock edge where `supply_low` is low and a request is pending, `clear_phase` goes high. It stays high for exactly `CLR_CYC` cycles.
- R3: `xfer_phase` goes high in the cycle after the last clear cycle and stays high for exactly `XFR_CYC` cycles. `ready` rises in the cycle after the last transfer cycle.
- R4: In any cycle where `supply_low` is high, `write_en`, `store_go` and `ready` are low in that same cycle.
- R5: If `supply_low` rises during either phase, the restore is abandoned and both phase outputs drop at the next edge. On recovery, a complete restore runs again from the start of the clear phase.
- R6: `write_en` is never high during a restore phase or while `store_busy` is high.
- R7: After a restore completes, or after `store_busy` falls, a write is passed only from the first cycle in which `ce_n` or `we_n` is seen going from 1 to 0 (compared to its value at the previous clock edge). A strobe pair held low throughout produces no write. From the edge cycle on, `write_en` = `ready & !ce_n & !we_n`.
- R8: `dirty` is set by a cycle with `write_en` high. It is cleared when a restore completes and while `store_busy` is high.
- R9: `store_go` equals `store_req` when `ready` is high and `store_busy` is low, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_low | input | 1 | Supply below threshold |
| ce_n | input | 1 | Chip-enable strobe, active low |
| we_n | input | 1 | Write-enable strobe, active low |
| store_req | input | 1 | Request to save the array to nonvolatile storage |
| store_busy | input | 1 | A save is running |
| clear_phase | output | 1 | Restore clear phase handshake |
| xfer_phase | output | 1 | Restore transfer phase handshake |
| ready | output | 1 | Array open for access |
| write_en | output | 1 | Gated write to the array |
| store_go | output | 1 | Save request passed to the save engine |
| dirty | output | 1 | A write was passed since the last restore or save |

## Verification
The hardest situation to reach is a supply drop in the middle of the clear phase. The drop must land after the phase has started but before the transfer begins. The stimulus gets there by releasing `supply_low` and raising it again two cycles later, while `CLR_CYC` is still running. It then checks that a full-length restore follows. The lockout is exercised with both strobes held low through the whole restore and through a save, so that only a deliberate strobe toggle can open the gate.

// File: rtl/nv_recall_guard.sv
module nv_recall_guard #(
  parameter int CLR_CYC = 4,
  parameter int XFR_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low,
  input  logic ce_n,
  input  logic we_n,
  input  logic store_req,
  input  logic store_busy,
  output logic clear_phase,
  output logic xfer_phase,
  output logic ready,
  output logic write_en,
  output logic store_go,
  output logic dirty
);
  localparam int MAXC = (CLR_CYC > XFR_CYC) ? CLR_CYC : XFR_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] CLR_LAST = CW'(CLR_CYC - 1);
  localparam logic [CW-1:0] XFR_LAST = CW'(XFR_CYC - 1);

  typedef enum logic [1:0] {S_OFF, S_CLR, S_XFR, S_RDY} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic pend, lock, ce_q, we_q;

  wire fell   = (ce_q & ~ce_n) | (we_q & ~we_n);
  wire xfr_end = (st == S_XFR) && (cnt == XFR_LAST) && !supply_low;

  assign clear_phase = (st == S_CLR);
  assign xfer_phase  = (st == S_XFR);
  assign ready       = (st == S_RDY) && !supply_low;
  assign write_en    = ready & ~store_busy & ~ce_n & ~we_n & (~lock | fell);
  assign store_go    = ready & ~store_busy & store_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_OFF;
      cnt   <= '0;
      pend  <= 1'b1;
      lock  <= 1'b1;
      ce_q  <= 1'b0;
      we_q  <= 1'b0;
      dirty <= 1'b0;
    end else begin
      ce_q <= ce_n;
      we_q <= we_n;
      if (supply_low) pend <= 1'b1;
      case (st)
        S_OFF: if (!supply_low && pend) begin
          st  <= S_CLR;
          cnt <= '0;
        end
        S_CLR:
          if (supply_low) st <= S_OFF;
          else if (cnt == CLR_LAST) begin
            st  <= S_XFR;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        S_XFR:
          if (supply_low) st <= S_OFF;
          else if (cnt == XFR_LAST) begin
            st   <= S_RDY;
            pend <= 1'b0;
          end else cnt <= cnt + 1'b1;
        default: if (supply_low) st <= S_OFF;
      endcase
      if (!ready || store_busy) lock <= 1'b1;
      else if (fell) lock <= 1'b0;
      if (xfr_end || store_busy) dirty <= 1'b0;
      else if (write_en) dirty <= 1'b1;
    end
  end

  a_r4_low_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |-> (!write_en && !store_go && !ready));
  a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (store_busy || clear_phase || xfer_phase) |-> !write_en);
  a_r3_clear_then_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_phase) |-> $past(clear_phase));
  a_r3_ready_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_RDY) |-> $past(xfer_phase));
  a_r7_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !fell) |-> !write_en);
  a_r8_dirty_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_RDY) |-> !dirty);
  a_r5_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_low && (clear_phase || xfer_phase)) |=> (!clear_phase && !xfer_phase));
endmodule

// File: tb/nv_recall_guard_bench.sv
module nv_recall_guard_bench;
  localparam int PERIOD = 10;
  localparam int CLR = 4;
  localparam int XFR = 6;
  // {ce_n, we_n, store_req, exp write_en, exp store_go}
  localparam logic [4:0] VEC [7] = '{
    5'b00000, 5'b01101, 5'b00010, 5'b00010, 5'b11000, 5'b01000, 5'b00010
  };

  logic clk = 0, rst_n = 0, supply_low = 1, ce_n = 0, we_n = 0, store_req = 0, store_busy = 0;
  logic clear_phase, xfer_phase, ready, write_en, store_go, dirty;
  int checks = 0, fails = 0;

  nv_recall_guard #(.CLR_CYC(CLR), .XFR_CYC(XFR)) u_nv_recall_guard (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .ce_n(ce_n), .we_n(we_n),
    .store_req(store_req), .store_busy(store_busy), .clear_phase(clear_phase),
    .xfer_phase(xfer_phase), .ready(ready), .write_en(write_en), .store_go(store_go),
    .dirty(dirty));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic recall_seq(input string tag);
    int f_clr = 0, n_clr = 0, f_xfr = 0, n_xfr = 0, f_rdy = 0, n_wen = 0;
    @(negedge clk) supply_low = 0;
    for (int i = 1; i <= CLR + XFR + 8; i++) begin
      @(negedge clk); #1;
      if (clear_phase) begin n_clr++; if (f_clr == 0) f_clr = i; end
      if (xfer_phase)  begin n_xfr++; if (f_xfr == 0) f_xfr = i; end
      if (ready && f_rdy == 0) f_rdy = i;
      if (write_en) n_wen++;
    end
    chk({"R2 clear start ", tag}, f_clr, 1);
    chk({"R2 clear length ", tag}, n_clr, CLR);
    chk({"R3 xfer start ", tag}, f_xfr, CLR + 1);
    chk({"R3 xfer length ", tag}, n_xfr, XFR);
    chk({"R3 ready start ", tag}, f_rdy, CLR + XFR + 1);
    chk({"R7 held strobes give no write ", tag}, n_wen, 0);
    chk({"R8 dirty cleared by restore ", tag}, dirty, 0);
  endtask

  initial begin
    #(PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset ready", ready, 0);
    chk("R1 reset clear", clear_phase, 0);
    chk("R1 reset xfer", xfer_phase, 0);
    chk("R8 reset dirty", dirty, 0);
    @(negedge clk) begin rst_n = 1; store_req = 1; end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk("R1 waiting no clear", clear_phase, 0);
      chk("R4 low no write", write_en, 0);
      chk("R4 low no store", store_go, 0);
    end
    store_req = 0;
    recall_seq("power-up");

    foreach (VEC[k]) begin
      @(negedge clk) begin ce_n = VEC[k][4]; we_n = VEC[k][3]; store_req = VEC[k][2]; end
      #1;
      chk($sformatf("R7 table write row %0d", k), write_en, VEC[k][1]);
      chk($sformatf("R9 table store row %0d", k), store_go, VEC[k][0]);
    end
    chk("R8 dirty after write", dirty, 1);

    @(negedge clk) begin store_busy = 1; store_req = 1; end
    #1;
    chk("R6 busy blocks write", write_en, 0);
    chk("R9 busy blocks store", store_go, 0);
    @(negedge clk) begin ce_n = 1; end
    @(negedge clk) begin ce_n = 0; store_req = 0; end
    #1;
    chk("R6 edge during busy no write", write_en, 0);
    @(negedge clk) store_busy = 0;
    #1;
    chk("R7 relock after save", write_en, 0);
    chk("R8 dirty cleared by save", dirty, 0);
    @(negedge clk);
    #1;
    chk("R7 still locked", write_en, 0);
    @(negedge clk) we_n = 1;
    @(negedge clk) we_n = 0;
    #1;
    chk("R7 fresh edge writes", write_en, 1);

    @(negedge clk) begin supply_low = 1; store_req = 1; end
    #1;
    chk("R4 dip write", write_en, 0);
    chk("R4 dip store", store_go, 0);
    chk("R4 dip ready", ready, 0);
    store_req = 0;
    recall_seq("after dip");

    @(negedge clk) supply_low = 1;
    @(negedge clk) supply_low = 0;
    @(negedge clk);
    #1;
    chk("R5 clear started", clear_phase, 1);
    @(negedge clk) supply_low = 1;
    @(negedge clk);
    #1;
    chk("R5 abort clear", clear_phase, 0);
    chk("R5 abort xfer", xfer_phase, 0);
    chk("R5 abort ready", ready, 0);
    recall_seq("after abort");

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule